// File: doc/BRIEF.md
# Switched-Capacitor Column Clock Generator

This block produces the two-phase switching clocks for a set of analog switched-capacitor columns. Everything runs on one fast system clock. Each candidate clock source arrives as a one-cycle enable pulse. Two of the sources are global system clocks. The other two are auxiliary clocks, and each auxiliary clock is picked by index from a bank of digital-block output pulses.

Each column chooses one of the four sources. It counts that source's pulses modulo four and derives two non-overlapping phases from the count. It also produces a drive-enable for the shared analog output bus. The enable is normally active only in the second half of the second phase, so the bus holds its last value while the column settles. A per-column full-phase bit and a global sample-and-hold bypass each widen the enable to the whole second phase.

Programming arrives on plain parallel inputs. A new source choice waits for the count to wrap, so a phase is never shortened.

Top module: `sc_col_clkgen`

## Requirements
- R1: Each column has a 2-bit source field, coded 0 = system clock A, 1 = system clock B, 2 = auxiliary clock 0, 3 = auxiliary clock 1. Only pulses of the active source advance that column. Column i uses bits [2i+1:2i] of `col_src_sel`.
- R2: Each auxiliary clock follows `dig_pulse[k]`, where k is the value of its own 3-bit index field.
- R3: Every active source pulse advances a modulo-4 count. `phi1` is high for counts 0 and 1, and `phi2` is high for counts 2 and 3, so each full two-phase period takes four source pulses.
- R4: `phi1` and `phi2` are never high together. The count steps 1→2 and 3→0 each hold both phases low for exactly one system-clock cycle.
- R5: When `col_drive_en` is set and neither override is active, `bus_drive` is high only while `phi2` is high and the count is 3.
- R6: When the column's `col_full_phase` bit is set, `bus_drive` follows `phi2` for the whole phase.
- R7: When `sh_bypass` is set, `bus_drive` follows `phi2` for the whole phase in every column.
- R8: When `col_drive_en` is clear, `bus_drive` stays low for that column.
- R9: A new source field value is taken only on the source pulse that wraps the count from 3 to 0. Before that pulse, the previous source keeps driving the column.
- R10: Synchronous reset sets every count to 0, takes the source fields as they are, and holds `phi1`, `phi2` and `bus_drive` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_a_pulse | input | 1 | System clock A enable pulse |
| sys_b_pulse | input | 1 | System clock B enable pulse |
| dig_pulse | input | NDIG (8) | Digital-block output pulses |
| aux0_idx | input | 3 | Index selecting auxiliary clock 0 |
| aux1_idx | input | 3 | Index selecting auxiliary clock 1 |
| col_src_sel | input | 2*NCOL (8) | Per-column source fields |
| col_drive_en | input | NCOL (4) | Per-column output-bus drive permission |
| col_full_phase | input | NCOL (4) | Per-column full-phase drive override |
| sh_bypass | input | 1 | Global sample-and-hold bypass |
| phi1 | output | NCOL (4) | First phase per column |
| phi2 | output | NCOL (4) | Second phase per column |
| bus_drive | output | NCOL (4) | Output-bus drive-enable per column |

## Verification
The assertions check on every cycle that the phases never overlap and that a one-cycle gap follows each phase change. They also check that the drive-enable only appears inside the second phase, and outside count 3 only when an override allows it. A further assertion checks that the latched source changes only at a wrap.

Some behaviour can only be shown by the bench's scenarios, run against a pulse-driven model. These include the four-pulse period under mixed source patterns and the routing of auxiliary clocks by index. They also include the deferred source switch, the widened and suppressed drive windows, and the reset state.

// File: rtl/sc_clk_pkg.sv
package sc_clk_pkg;

    typedef enum logic [1:0] {
        SRC_SYS_A = 2'd0,
        SRC_SYS_B = 2'd1,
        SRC_AUX0  = 2'd2,
        SRC_AUX1  = 2'd3
    } src_sel_e;

    localparam int NUM_SRC = 4;

    typedef struct packed {
        logic [1:0] cnt;
        logic       gap;
        src_sel_e   sel;
    } phase_st_t;

    // Count 3 is the late half of the second phase.
    function automatic logic late_half(input logic [1:0] c);
        return c == 2'd3;
    endfunction

    // Counts 1 and 3 sit just before a window change.
    function automatic logic at_window_end(input logic [1:0] c);
        return c[0];
    endfunction

endpackage

// File: rtl/sc_aux_pick.sv
module sc_aux_pick #(
    parameter int NDIG  = 8,
    parameter int SEL_W = 3
) (
    input  logic [NDIG-1:0]  dig_pulse,
    input  logic [SEL_W-1:0] idx,
    output logic             aux_pulse
);
    always_comb begin
        aux_pulse = 1'b0;
        for (int k = 0; k < NDIG; k++) begin
            if (idx == SEL_W'(k)) aux_pulse = dig_pulse[k];
        end
    end
endmodule

// File: rtl/sc_col_phase.sv
module sc_col_phase
    import sc_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_pulses,
    input  logic [1:0]         sel_in,
    input  logic               drive_en,
    input  logic               full_phase,
    input  logic               sh_bypass,
    output logic               phi1,
    output logic               phi2,
    output logic               bus_drive
);
    phase_st_t st_q, st_d;
    logic      pulse;

    assign pulse = src_pulses[st_q.sel];

    always_comb begin
        st_d     = st_q;
        st_d.gap = 1'b0;
        if (pulse) begin
            st_d.cnt = st_q.cnt + 2'd1;
            st_d.gap = at_window_end(st_q.cnt);
            if (late_half(st_q.cnt)) st_d.sel = src_sel_e'(sel_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= 2'd0;
            st_q.gap <= 1'b1;
            st_q.sel <= src_sel_e'(sel_in);
        end else begin
            st_q <= st_d;
        end
    end

    assign phi1      = !st_q.gap && !st_q.cnt[1];
    assign phi2      = !st_q.gap &&  st_q.cnt[1];
    assign bus_drive = drive_en && phi2 &&
                       (late_half(st_q.cnt) || full_phase || sh_bypass);

    // R4
    phase_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(phi1 && phi2));
    // R4
    gap_after_phi1_chk: assert property (@(posedge clk) disable iff (rst)
        phi1 && !phi2 |=> !phi2);
    // R4
    gap_after_phi2_chk: assert property (@(posedge clk) disable iff (rst)
        phi2 |=> !phi1);
    // R5
    drive_inside_phi2_chk: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> phi2 && drive_en);
    // R5
    drive_late_half_chk: assert property (@(posedge clk) disable iff (rst)
        bus_drive && !full_phase && !sh_bypass |-> st_q.cnt == 2'd3);
    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(pulse && st_q.cnt == 2'd3) |=> $stable(st_q.sel));
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !phi1 && !phi2 && !bus_drive);
endmodule

// File: rtl/sc_col_clkgen.sv
module sc_col_clkgen
    import sc_clk_pkg::*;
#(
    parameter int NCOL = 4,
    parameter int NDIG = 8,
    localparam int ASEL_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sys_a_pulse,
    input  logic                 sys_b_pulse,
    input  logic [NDIG-1:0]      dig_pulse,
    input  logic [ASEL_W-1:0]    aux0_idx,
    input  logic [ASEL_W-1:0]    aux1_idx,
    input  logic [2*NCOL-1:0]    col_src_sel,
    input  logic [NCOL-1:0]      col_drive_en,
    input  logic [NCOL-1:0]      col_full_phase,
    input  logic                 sh_bypass,
    output logic [NCOL-1:0]      phi1,
    output logic [NCOL-1:0]      phi2,
    output logic [NCOL-1:0]      bus_drive
);
    logic               aux0_pulse, aux1_pulse;
    logic [NUM_SRC-1:0] src_pulses;

    sc_aux_pick #(.NDIG(NDIG), .SEL_W(ASEL_W)) u_aux0 (
        .dig_pulse(dig_pulse), .idx(aux0_idx), .aux_pulse(aux0_pulse));
    sc_aux_pick #(.NDIG(NDIG), .SEL_W(ASEL_W)) u_aux1 (
        .dig_pulse(dig_pulse), .idx(aux1_idx), .aux_pulse(aux1_pulse));

    assign src_pulses = {aux1_pulse, aux0_pulse, sys_b_pulse, sys_a_pulse};

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        sc_col_phase u_col (
            .clk       (clk),
            .rst       (rst),
            .src_pulses(src_pulses),
            .sel_in    (col_src_sel[2*c +: 2]),
            .drive_en  (col_drive_en[c]),
            .full_phase(col_full_phase[c]),
            .sh_bypass (sh_bypass),
            .phi1      (phi1[c]),
            .phi2      (phi2[c]),
            .bus_drive (bus_drive[c])
        );
    end

    // R2
    aux_source_chk: assert property (@(posedge clk) disable iff (rst)
        (aux0_pulse || aux1_pulse) |-> |dig_pulse);
endmodule

// File: tb/sim_sc_col_clkgen.sv
`timescale 1ns/1ps
module sim_sc_col_clkgen;
    localparam int NCOL = 4;
    localparam int NDIG = 8;
    localparam int NVEC = 16;
    // {sys_a, sys_b, dig[7:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b10_00000000, 10'b00_00100000, 10'b01_00000100, 10'b10_00100100,
        10'b00_00000000, 10'b11_11111111, 10'b10_00000000, 10'b01_00100000,
        10'b10_00000100, 10'b00_00000000, 10'b11_00100100, 10'b10_00000000,
        10'b01_00100100, 10'b10_00000000, 10'b00_00100000, 10'b11_00000100
    };

    logic clk = 0, rst = 1, sys_a = 0, sys_b = 0, byp = 0;
    logic [NDIG-1:0] dig = '0;
    logic [2:0] a0 = 3'd5, a1 = 3'd2;
    logic [2*NCOL-1:0] sel = {2'd3, 2'd2, 2'd1, 2'd0};
    logic [NCOL-1:0] den = 4'b1111, fph = 4'b0010;
    logic [NCOL-1:0] phi1, phi2, bdrv;
    int total = 0, bad = 0;
    int mcnt [NCOL];
    bit mgap [NCOL];
    logic [1:0] msel [NCOL];

    always #4 clk = ~clk;

    sc_col_clkgen #(.NCOL(NCOL), .NDIG(NDIG)) u0 (
        .clk(clk), .rst(rst), .sys_a_pulse(sys_a), .sys_b_pulse(sys_b),
        .dig_pulse(dig), .aux0_idx(a0), .aux1_idx(a1), .col_src_sel(sel),
        .col_drive_en(den), .col_full_phase(fph), .sh_bypass(byp),
        .phi1(phi1), .phi2(phi2), .bus_drive(bdrv));

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_check(input string tag);
        logic [NCOL-1:0] e1, e2, ed;
        for (int c = 0; c < NCOL; c++) begin
            e1[c] = !mgap[c] && mcnt[c] < 2;
            e2[c] = !mgap[c] && mcnt[c] >= 2;
            ed[c] = den[c] && e2[c] && (mcnt[c] == 3 || fph[c] || byp);
        end
        check(tag, {phi1, phi2, bdrv}, {e1, e2, ed});
    endtask

    task automatic step(input logic [9:0] v, input string tag);
        logic [3:0] srcs;
        {sys_a, sys_b, dig} = v;
        @(negedge clk);
        srcs = {dig[a1], dig[a0], v[8], v[9]};
        for (int c = 0; c < NCOL; c++) begin
            if (srcs[msel[c]]) begin
                if (mcnt[c] == 3) msel[c] = sel[2*c +: 2];
                mgap[c] = (mcnt[c] == 1 || mcnt[c] == 3);
                mcnt[c] = (mcnt[c] + 1) % 4;
            end else mgap[c] = 0;
        end
        {sys_a, sys_b, dig} = '0;
        model_check(tag);
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        for (int c = 0; c < NCOL; c++) begin
            mcnt[c] = 0; mgap[c] = 1; msel[c] = sel[2*c +: 2];
        end
        check("R10 reset", {phi1, phi2, bdrv}, 12'h000);
        rst = 0;
    endtask

    initial begin
        #(8 * 20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 R2 R3 R4 R5 R6: mixed pulse patterns across all columns
        for (int i = 0; i < NVEC; i++) step(VEC[i], "R1/R2/R3/R4/R5/R6 table");
        // R3: four pulses of source A give one period on column 0
        do_reset();
        step(10'b10_00000000, "R3 cnt1");
        check("R3 phi1 at count1", {phi1[0], phi2[0]}, 12'b10);
        step(10'b10_00000000, "R3 cnt2 gap");
        check("R4 gap", {phi1[0], phi2[0]}, 12'b00);
        step(10'b00_00000000, "R3 phi2");
        check("R3 phi2 at count2", {phi1[0], phi2[0]}, 12'b01);
        step(10'b10_00000000, "R5 cnt3");
        check("R5 drive at count3", {10'b0, phi2[0], bdrv[0]}, 12'b11);
        step(10'b10_00000000, "R4 wrap gap");
        // R7: global bypass widens every column
        byp = 1;
        for (int i = 0; i < NVEC; i++) step(VEC[i], "R7 bypass");
        byp = 0;
        // R8: drive permission removed
        den = 4'b0000; fph = 4'b1111;
        for (int i = 0; i < 8; i++) step(VEC[i], "R8 no drive");
        den = 4'b1111; fph = 4'b0000;
        // R9: column 0 switches A->B only at wrap
        do_reset();
        step(10'b10_00000000, "R9 a1");
        sel[1:0] = 2'd1;
        step(10'b01_00000000, "R9 b ignored");
        check("R9 still count1", {phi1[0], phi2[0]}, 12'b10);
        step(10'b10_00000000, "R9 a2");
        step(10'b10_00000000, "R9 a3");
        step(10'b10_00000000, "R9 wrap");
        step(10'b10_00000000, "R9 a ignored");
        check("R9 old source ignored", {phi1[0], phi2[0]}, 12'b10);
        step(10'b01_00000000, "R9 b1");
        step(10'b01_00000000, "R9 b2");
        step(10'b00_00000000, "R9 phi2 via b");
        check("R9 new source drives", {phi1[0], phi2[0]}, 12'b01);
        // R2: change aux index, column 2 now follows dig[7]
        a0 = 3'd7;
        for (int i = 0; i < 6; i++) step(10'b00_00100000, "R2 old index idle");
        for (int i = 0; i < 6; i++) step(10'b00_10000000, "R2 new index");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule